// File: doc/BRIEF.md
# Local Core Reset Handshake Controller

This block sits next to a pipelined processor core and sequences a reset of that core alone, leaving the rest of the system running. When a local reset request arrives, the controller stops new instruction issue. It waits for the pipeline to report that it is empty, then puts the core into its held reset state. In that state it tells the requester that the reset has happened, and it repeats that indication while the request stays high. It also issues dummy reads of the reset address at the same repeat rate; the data returned by these reads is discarded. Once the request drops, the core is released to fetch from the reset address.

The controller also arbitrates debugger control. A debug request pauses the core, redirects it to the break address and raises an acknowledge. A reset request that arrives while the core is paused is not acted on. That request is honoured as soon as the debugger lets go, either for a full resume or for the one-cycle release of a single step. A global synchronous reset overrides everything and holds the core in reset in the same cycle, without any handshake.

Top module: `core_rst_handshake`

## Requirements
- R1: While `rst` is high, `core_hold_o` is high in that same cycle. On the first cycle after `rst` falls, the controller is in the running state: `core_hold_o`, `issue_stall_o`, `dbg_ack_o`, `taken_o`, `rd_req_o`, `fetch_go_o` and `redirect_o` are all low, and `tgt_addr_o` is 0.
- R2: A reset request is accepted in a running cycle (no debug request in that cycle) or in a step cycle. If `pipe_empty_i` is low in that cycle, the controller drains: `core_hold_o` stays low until `pipe_empty_i` is seen high.
- R3: `issue_stall_o` is high in the cycle a request is accepted and in every drain cycle. It is low in all other states.
- R4: The cycle after `pipe_empty_i` is seen high during acceptance or drain, `core_hold_o` goes high. It stays high as long as `rst_req_i` stays high.
- R5: `taken_o` is high for exactly one cycle on the first held cycle. It is then high again every REPEAT cycles while the request is held, and is never high in two consecutive cycles.
- R6: `rd_req_o` is high in exactly the cycles where `taken_o` is high, and in those cycles `tgt_addr_o` equals RESET_ADDR.
- R7: When `rst_req_i` is low in a held cycle, the next cycle has `core_hold_o` low and a one-cycle `fetch_go_o` with `tgt_addr_o` equal to RESET_ADDR.
- R8: A debug request in a running cycle takes priority over a reset request in that same cycle. In the next cycle `dbg_ack_o` is high and `redirect_o` pulses for one cycle with `tgt_addr_o` equal to BREAK_ADDR.
- R9: While paused, `rst_req_i` and `dbg_req_i` have no effect. `dbg_ack_o` stays high, `core_hold_o` and `issue_stall_o` stay low, and no new `redirect_o` pulse occurs.
- R10: `dbg_step_i` while paused gives exactly one step cycle with `dbg_ack_o` low. A reset request present in that cycle is accepted; otherwise the controller is paused again the following cycle.
- R11: `dbg_resume_i` while paused returns the controller to running on the next cycle. A reset request still pending there is accepted in that first running cycle. `dbg_resume_i` takes priority over `dbg_step_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| rst_req_i | input | 1 | Local reset request, held by the requester |
| dbg_req_i | input | 1 | Debug pause request |
| dbg_resume_i | input | 1 | Debugger resumes normal execution |
| dbg_step_i | input | 1 | Debugger grants a single-step release |
| pipe_empty_i | input | 1 | Core reports no instructions in flight |
| core_hold_o | output | 1 | Core held in reset state |
| issue_stall_o | output | 1 | Block new instruction issue |
| taken_o | output | 1 | Reset-done pulse, repeated while request held |
| rd_req_o | output | 1 | Dummy read strobe to the reset address |
| fetch_go_o | output | 1 | Release pulse: fetch from reset address |
| dbg_ack_o | output | 1 | Core paused under debugger control |
| redirect_o | output | 1 | Pulse: redirect execution to break address |
| tgt_addr_o | output | ADDR_W | Address accompanying rd_req_o, fetch_go_o or redirect_o, else 0 |

## Verification
The bench builds the block with REPEAT set to 5, a 16-bit address width and non-zero reset and break addresses. The short interval lets several repeated taken pulses and dummy reads occur within a single held stretch, and puts the wrap of the interval counter within reach of both directed and random stimulus. Distinct addresses make a mix-up between the reset and break addresses on `tgt_addr_o` visible. The random phase holds the request for long stretches while debug pauses, steps and resumes interleave with it.

// File: rtl/core_rst_handshake_pkg.sv
package core_rst_handshake_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_HELD   = 3'd2,
        ST_PAUSED = 3'd3,
        ST_STEP   = 3'd4
    } hs_state_e;

    typedef struct packed {
        logic go_held;
        logic go_release;
        logic go_pause;
    } hs_event_t;

    function automatic logic can_accept(hs_state_e st, logic dbg_req);
        return (st == ST_STEP) || ((st == ST_RUN) && !dbg_req);
    endfunction

endpackage

// File: rtl/core_rst_hs_fsm.sv
module core_rst_hs_fsm
    import core_rst_handshake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rst_req_i,
    input  logic      dbg_req_i,
    input  logic      dbg_resume_i,
    input  logic      dbg_step_i,
    input  logic      pipe_empty_i,
    output hs_state_e state_o,
    output hs_event_t evt_o,
    output logic      accept_o
);

    hs_state_e st_q, st_d;
    hs_event_t evt;

    assign accept_o = rst_req_i && can_accept(st_q, dbg_req_i);

    always_comb begin
        st_d = st_q;
        evt  = '0;
        unique case (st_q)
            ST_RUN: begin
                if (dbg_req_i) begin
                    st_d         = ST_PAUSED;
                    evt.go_pause = 1'b1;
                end else if (rst_req_i) begin
                    if (pipe_empty_i) begin
                        st_d        = ST_HELD;
                        evt.go_held = 1'b1;
                    end else begin
                        st_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (pipe_empty_i) begin
                    st_d        = ST_HELD;
                    evt.go_held = 1'b1;
                end
            end
            ST_HELD: begin
                if (!rst_req_i) begin
                    st_d           = ST_RUN;
                    evt.go_release = 1'b1;
                end
            end
            ST_PAUSED: begin
                if (dbg_resume_i)    st_d = ST_RUN;
                else if (dbg_step_i) st_d = ST_STEP;
            end
            ST_STEP: begin
                if (rst_req_i) begin
                    if (pipe_empty_i) begin
                        st_d        = ST_HELD;
                        evt.go_held = 1'b1;
                    end else begin
                        st_d = ST_DRAIN;
                    end
                end else begin
                    st_d = ST_PAUSED;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
    assign evt_o   = evt;

endmodule

// File: rtl/core_rst_hs_timer.sv
module core_rst_hs_timer #(
    parameter int REPEAT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    output logic fire_o
);

    localparam int CNT_W = (REPEAT > 2) ? $clog2(REPEAT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REPEAT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign fire_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear_i)  cnt_q <= '0;
        else if (fire_o)     cnt_q <= '0;
        else if (run_i)      cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/core_rst_hs_pulses.sv
module core_rst_hs_pulses
    import core_rst_handshake_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter logic [ADDR_W-1:0] BREAK_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  hs_event_t         evt_i,
    input  logic              fire_i,
    output logic              taken_o,
    output logic              rd_req_o,
    output logic              fetch_go_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] tgt_addr_o
);

    logic taken_q, rd_q, fetch_q, redir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            rd_q    <= 1'b0;
            fetch_q <= 1'b0;
            redir_q <= 1'b0;
        end else begin
            taken_q <= evt_i.go_held | fire_i;
            rd_q    <= evt_i.go_held | fire_i;
            fetch_q <= evt_i.go_release;
            redir_q <= evt_i.go_pause;
        end
    end

    always_comb begin
        if (rd_q || fetch_q) tgt_addr_o = RESET_ADDR;
        else if (redir_q)    tgt_addr_o = BREAK_ADDR;
        else                 tgt_addr_o = '0;
    end

    assign taken_o    = taken_q;
    assign rd_req_o   = rd_q;
    assign fetch_go_o = fetch_q;
    assign redirect_o = redir_q;

endmodule

// File: rtl/core_rst_handshake.sv
module core_rst_handshake
    import core_rst_handshake_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter logic [ADDR_W-1:0] BREAK_ADDR = ADDR_W'(32'h20),
    parameter int                REPEAT     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_i,
    input  logic              dbg_req_i,
    input  logic              dbg_resume_i,
    input  logic              dbg_step_i,
    input  logic              pipe_empty_i,
    output logic              core_hold_o,
    output logic              issue_stall_o,
    output logic              taken_o,
    output logic              rd_req_o,
    output logic              fetch_go_o,
    output logic              dbg_ack_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] tgt_addr_o
);

    hs_state_e st;
    hs_event_t evt;
    logic      accept;
    logic      fire;

    core_rst_hs_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .rst_req_i    (rst_req_i),
        .dbg_req_i    (dbg_req_i),
        .dbg_resume_i (dbg_resume_i),
        .dbg_step_i   (dbg_step_i),
        .pipe_empty_i (pipe_empty_i),
        .state_o      (st),
        .evt_o        (evt),
        .accept_o     (accept)
    );

    core_rst_hs_timer #(.REPEAT(REPEAT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear_i (evt.go_held),
        .run_i   ((st == ST_HELD) && rst_req_i),
        .fire_o  (fire)
    );

    core_rst_hs_pulses #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR),
        .BREAK_ADDR (BREAK_ADDR)
    ) u_pulses (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .fire_i     (fire),
        .taken_o    (taken_o),
        .rd_req_o   (rd_req_o),
        .fetch_go_o (fetch_go_o),
        .redirect_o (redirect_o),
        .tgt_addr_o (tgt_addr_o)
    );

    assign core_hold_o   = rst || (st == ST_HELD);
    assign issue_stall_o = !rst && (accept || (st == ST_DRAIN));
    assign dbg_ack_o     = !rst && (st == ST_PAUSED);

endmodule

// File: rtl/core_rst_handshake_chk.sv
module core_rst_handshake_chk #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter logic [ADDR_W-1:0] BREAK_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_req_i,
    input logic              core_hold_o,
    input logic              issue_stall_o,
    input logic              taken_o,
    input logic              rd_req_o,
    input logic              fetch_go_o,
    input logic              dbg_ack_o,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] tgt_addr_o
);

    AST_GLOBAL_HOLD: assert property (@(posedge clk) rst |-> core_hold_o) // R1
        else $error("global reset without hold");

    AST_TAKEN_IN_HELD: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> core_hold_o) // R5
        else $error("taken outside held state");

    AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        taken_o |=> !taken_o) // R5
        else $error("taken longer than one cycle");

    AST_READ_ADDR: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (taken_o && tgt_addr_o == RESET_ADDR)) // R6
        else $error("dummy read mismatch");

    AST_RELEASE_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_go_o |-> (!core_hold_o && tgt_addr_o == RESET_ADDR)) // R7
        else $error("fetch release mismatch");

    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (core_hold_o && rst_req_i) |=> core_hold_o) // R4
        else $error("hold dropped while request held");

    AST_REDIRECT_ACK: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (dbg_ack_o && tgt_addr_o == BREAK_ADDR)) // R8
        else $error("redirect without pause");

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        dbg_ack_o |-> (!core_hold_o && !issue_stall_o)) // R9
        else $error("paused core touched by reset");

endmodule

bind core_rst_handshake core_rst_handshake_chk #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR),
    .BREAK_ADDR (BREAK_ADDR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rst_req_i     (rst_req_i),
    .core_hold_o   (core_hold_o),
    .issue_stall_o (issue_stall_o),
    .taken_o       (taken_o),
    .rd_req_o      (rd_req_o),
    .fetch_go_o    (fetch_go_o),
    .dbg_ack_o     (dbg_ack_o),
    .redirect_o    (redirect_o),
    .tgt_addr_o    (tgt_addr_o)
);

// File: tb/tb_core_rst_handshake.sv
module tb_core_rst_handshake;

    localparam int              AW    = 16;
    localparam logic [AW-1:0]   R_ADR = 16'h0400;
    localparam logic [AW-1:0]   B_ADR = 16'h0C20;
    localparam int              REP   = 5;

    localparam int M_RUN = 0, M_DRAIN = 1, M_HELD = 2, M_PAUSED = 3, M_STEP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, dbg = 1'b0, res = 1'b0, stp = 1'b0, emp = 1'b0;
    logic hold, stall, taken, rd, fetch, ack, redir;
    logic [AW-1:0] addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int m_st = M_RUN;
    int m_cnt = 0;
    bit m_taken = 0, m_fetch = 0, m_redir = 0;

    always #10 clk = ~clk;

    core_rst_handshake #(
        .ADDR_W(AW), .RESET_ADDR(R_ADR), .BREAK_ADDR(B_ADR), .REPEAT(REP)
    ) dut (
        .clk(clk), .rst(rst), .rst_req_i(req), .dbg_req_i(dbg),
        .dbg_resume_i(res), .dbg_step_i(stp), .pipe_empty_i(emp),
        .core_hold_o(hold), .issue_stall_o(stall), .taken_o(taken),
        .rd_req_o(rd), .fetch_go_o(fetch), .dbg_ack_o(ack),
        .redirect_o(redir), .tgt_addr_o(addr)
    );

    function automatic bit exp_accept();
        return req && ((m_st == M_STEP) || (m_st == M_RUN && !dbg));
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        if (m_taken || m_fetch) return R_ADR;
        if (m_redir)            return B_ADR;
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic model_step();
        bit go_held = 0;
        m_taken = 0; m_fetch = 0; m_redir = 0;
        if (rst) begin
            m_st = M_RUN; m_cnt = 0;
            return;
        end
        case (m_st)
            M_RUN: if (dbg) begin m_st = M_PAUSED; m_redir = 1; end
                   else if (req) begin if (emp) go_held = 1; else m_st = M_DRAIN; end
            M_DRAIN: if (emp) go_held = 1;
            M_HELD: if (!req) begin m_st = M_RUN; m_fetch = 1; end
                    else if (m_cnt == REP - 1) begin m_cnt = 0; m_taken = 1; end
                    else m_cnt++;
            M_PAUSED: if (res) m_st = M_RUN; else if (stp) m_st = M_STEP;
            M_STEP: if (req) begin if (emp) go_held = 1; else m_st = M_DRAIN; end
                    else m_st = M_PAUSED;
            default: m_st = M_RUN;
        endcase
        if (go_held) begin m_st = M_HELD; m_cnt = 0; m_taken = 1; end
    endtask

    // One cycle: drive at negedge, check outputs, advance model.
    task automatic cyc(input bit r, input bit q, input bit d, input bit rs, input bit s, input bit e);
        @(negedge clk);
        rst = r; req = q; dbg = d; res = rs; stp = s; emp = e;
        #1;
        chk("R1/R4 core_hold_o", AW'(hold), AW'(rst || m_st == M_HELD));
        chk("R2/R3 issue_stall_o", AW'(stall), AW'(!rst && (exp_accept() || m_st == M_DRAIN)));
        chk("R5 taken_o", AW'(taken), AW'(m_taken));
        chk("R6 rd_req_o", AW'(rd), AW'(m_taken));
        chk("R7 fetch_go_o", AW'(fetch), AW'(m_fetch));
        chk("R8/R9/R10 dbg_ack_o", AW'(ack), AW'(!rst && m_st == M_PAUSED));
        chk("R8 redirect_o", AW'(redir), AW'(m_redir));
        chk("R6/R7/R8 tgt_addr_o", addr, exp_addr());
        model_step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1357));
        // R1: global reset and idle state afterwards
        cyc(1, 1, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R2 R3 R4: drain for three cycles, then held
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 1);
        // R5 R6: hold the request over several repeat intervals
        for (int i = 0; i < 3 * REP + 2; i++) cyc(0, 1, 0, 0, 0, 1);
        // R7: release
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R8: debug wins over reset request in the same cycle
        cyc(0, 1, 1, 0, 0, 1);
        // R9: requests and further debug requests ignored while paused
        for (int i = 0; i < 6; i++) cyc(0, 1, i[0], 0, 0, 1);
        // R10: step without request returns to paused
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R10: step with request accepted, drains first
        cyc(0, 1, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R11: pause, request pending, resume (resume beats step)
        cyc(0, 0, 1, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        cyc(0, 1, 0, 1, 1, 1);
        cyc(0, 1, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R1: global reset in the middle of a held stretch
        cyc(0, 1, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        cyc(1, 1, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // Random phase
        begin
            bit q = 0;
            for (int n = 0; n < 4000; n++) begin
                if ($urandom_range(0, 9) == 0) q = !q;
                cyc(($urandom_range(0, 199) == 0),
                    q,
                    ($urandom_range(0, 11) == 0),
                    ($urandom_range(0, 7) == 0),
                    ($urandom_range(0, 5) == 0),
                    ($urandom_range(0, 2) == 0));
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule